// File: doc/BRIEF.md
# SPI Master Byte Shift Engine

This block is the serial datapath of an SPI master that talks to a sensor. It derives a serial clock from the system clock by a fixed divide, with ten system clocks per serial bit. It shifts command bytes out on MOSI, most significant bit first, and shifts the reply bits in from MISO at the same time. Chip select follows an active-low transfer enable. While the transfer is enabled, bytes stream back to back with no gap and no handshake.

Transmit bytes come from an external command FIFO. The engine pulses an active-low read strobe at a fixed point at the start of every byte. It expects the FIFO to present that byte on the next clock, and loads it into the transmit shifter on that clock. Each received byte is handed to an external receive FIFO through an active-low write strobe, which fires at a fixed point near the end of the byte. Separate active-low send and receive enables gate the two strobes. A byte counter counts completed bytes. It is cleared by the sequencer once the transfer has ended and the sequencer raises its done flag.

Top module: `spi_byte_engine`

## Requirements
- R1: A serial bit period is exactly ten system clocks. An internal phase counter runs 0 to 9 and wraps to 0.
- R2: A 3-bit bit counter advances each time the phase counter wraps. One byte is therefore 80 clocks, and consecutive bytes follow with no gap.
- R3: While `xfer_en_n` is high, both counters are held at zero, `sck` is 0 and `mosi` is 0. When `xfer_en_n` falls, the new transfer starts at bit 0, phase 0.
- R4: The transmit byte is loaded on the clock edge that ends phase 1 of bit 0, the clock after the read strobe. It is sent MSB first, and after each bit period the shifter moves left with zero fill. With sending disabled, nothing is loaded and `mosi` stays 0.
- R5: MISO is sampled on the clock edge where `sck` rises (the edge ending phase 4) and enters at the LSB. After eight bits, `rx_data` holds the byte with the first received bit in bit 7.
- R6: `tx_rd_n` is low for exactly one clock per byte, during bit 0, phase 0, and only when `send_en_n` is low.
- R7: `rx_wr_n` is low for exactly one clock per byte, during bit 7, phase 6, and only when `recv_en_n` is low.
- R8: `sck` has clock polarity 0. It is low during phases 0 to 4 and high during phases 5 to 9 of each bit.
- R9: `byte_count` increments on the edge ending bit 7, phase 7, whether or not the strobes are enabled. It holds its value otherwise. It clears to 0 on the clock after a cycle in which `xfer_en_n` and `done_i` are both high.
- R10: `cs_n` is low exactly while `xfer_en_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_en_n | input | 1 | Transfer enable, active low |
| send_en_n | input | 1 | Send enable, active low; gates the read strobe and the load |
| recv_en_n | input | 1 | Receive enable, active low; gates the write strobe |
| done_i | input | 1 | Done flag from the sequencer; clears the byte counter when the transfer is off |
| tx_data | input | 8 | Byte from the command FIFO, valid the clock after `tx_rd_n` |
| tx_rd_n | output | 1 | Command FIFO read strobe, active low |
| miso | input | 1 | Serial data from the slave |
| rx_data | output | 8 | Receive shifter contents |
| rx_wr_n | output | 1 | Receive FIFO write strobe, active low |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Chip select, active low |
| byte_count | output | 16 | Completed byte count |

## Verification
The assertions check every cycle that the phase stays in range and that the bit counter steps only at a wrap. They also check that the counters, `sck` and `mosi` are quiet while the transfer is off and that each strobe is a single-clock pulse. Finally, they check the one-cycle load and sample behaviour of the two shifters and that the counter clears on done. Only the bench scenarios show the absolute timing: the strobes landing at bit 0 phase 0 and at bit 7 phase 6, MSB-first serial order, the received byte matching the MISO pattern, and correct counts across several back-to-back bytes. The bench also covers a mid-byte abort, a restart, and a run with both enables off.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    parameter int SPI_DIV_DEFAULT  = 10;
    parameter int SPI_BITS_DEFAULT = 8;

    // Decoded per-cycle events of a bit period
    typedef struct packed {
        logic rd_hit;
        logic load;
        logic shift;
        logic sample;
        logic wr_hit;
        logic cnt_hit;
    } spi_evt_t;
endpackage

// File: rtl/spi_eng_timer.sv
module spi_eng_timer #(
    parameter int DIV  = spi_eng_pkg::SPI_DIV_DEFAULT,
    parameter int BITS = spi_eng_pkg::SPI_BITS_DEFAULT,
    localparam int PW  = $clog2(DIV),
    localparam int BW  = $clog2(BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [PW-1:0] phase_o,
    output logic [BW-1:0] bit_o
);
    localparam logic [PW-1:0] PH_LAST  = PW'(DIV - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(BITS - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic [BW-1:0] bitc;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d = '0;
        end else if (tmr_q.phase == PH_LAST) begin
            tmr_d.phase = '0;
            tmr_d.bitc  = (tmr_q.bitc == BIT_LAST) ? '0 : tmr_q.bitc + 1'b1;
        end else begin
            tmr_d.phase = tmr_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign phase_o = tmr_q.phase;
    assign bit_o   = tmr_q.bitc;

    // R1: phase never leaves 0..DIV-1
    p_phase_range_r1: assert property (@(posedge clk) disable iff (rst)
        tmr_q.phase <= PH_LAST);

    // R3: counters forced to zero while idle
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> (tmr_q.phase == '0) && (tmr_q.bitc == '0));

    // R2: bit counter steps at a wrap
    p_bit_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run && tmr_q.phase == PH_LAST) |=>
        (tmr_q.bitc == (($past(tmr_q.bitc) == BIT_LAST) ? '0 : $past(tmr_q.bitc) + 1'b1)));

    // R2: bit counter holds inside a bit period
    p_bit_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (run && tmr_q.phase != PH_LAST) |=> $stable(tmr_q.bitc));
endmodule

// File: rtl/spi_eng_tx.sv
module spi_eng_tx #(
    parameter int W = spi_eng_pkg::SPI_BITS_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         mosi
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!run)       sh_d = '0;
        else if (load)  sh_d = din;
        else if (shift) sh_d = {sh_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign mosi = run & sh_q[W-1];

    // R4: a load captures the FIFO byte on that edge
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (run && load) |=> (sh_q == $past(din)));

    // R4: a shift moves the MSB out and fills zero
    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (run && shift && !load) |=> (sh_q[0] == 1'b0) && (sh_q[W-1] == $past(sh_q[W-2])));
endmodule

// File: rtl/spi_eng_rx.sv
module spi_eng_rx #(
    parameter int W = spi_eng_pkg::SPI_BITS_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         sample,
    input  logic         miso,
    output logic [W-1:0] dout
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!run)        sh_d = '0;
        else if (sample) sh_d = {sh_q[W-2:0], miso};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign dout = sh_q;

    // R5: the sampled bit enters at the LSB and older bits move up
    p_sample_r5: assert property (@(posedge clk) disable iff (rst)
        (run && sample) |=> (sh_q[0] == $past(miso)) && (sh_q[W-1:1] == $past(sh_q[W-2:0])));
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int DIV   = spi_eng_pkg::SPI_DIV_DEFAULT,
    parameter int BITS  = spi_eng_pkg::SPI_BITS_DEFAULT,
    parameter int CNT_W = 16,
    localparam int PW   = $clog2(DIV),
    localparam int BW   = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_en_n,
    input  logic             send_en_n,
    input  logic             recv_en_n,
    input  logic             done_i,
    input  logic [BITS-1:0]  tx_data,
    output logic             tx_rd_n,
    input  logic             miso,
    output logic [BITS-1:0]  rx_data,
    output logic             rx_wr_n,
    output logic             sck,
    output logic             mosi,
    output logic             cs_n,
    output logic [CNT_W-1:0] byte_count
);
    import spi_eng_pkg::*;

    localparam int HALF = DIV / 2;
    localparam logic [PW-1:0] PH_RD   = PW'(0);
    localparam logic [PW-1:0] PH_LOAD = PW'(1);
    localparam logic [PW-1:0] PH_SAMP = PW'(HALF - 1);
    localparam logic [PW-1:0] PH_HIGH = PW'(HALF);
    localparam logic [PW-1:0] PH_WR   = PW'(HALF + 1);
    localparam logic [PW-1:0] PH_CNT  = PW'(HALF + 2);
    localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(BITS - 1);

    logic          run;
    logic [PW-1:0] phase;
    logic [BW-1:0] bitc;
    spi_evt_t      evt;

    assign run = !xfer_en_n;

    spi_eng_timer #(.DIV(DIV), .BITS(BITS)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .phase_o (phase),
        .bit_o   (bitc)
    );

    always_comb begin
        evt         = '0;
        evt.rd_hit  = run && (bitc == '0) && (phase == PH_RD) && !send_en_n;
        evt.load    = run && (bitc == '0) && (phase == PH_LOAD) && !send_en_n;
        evt.shift   = run && (phase == PH_LAST);
        evt.sample  = run && (phase == PH_SAMP);
        evt.wr_hit  = run && (bitc == BIT_LAST) && (phase == PH_WR) && !recv_en_n;
        evt.cnt_hit = run && (bitc == BIT_LAST) && (phase == PH_CNT);
    end

    spi_eng_tx #(.W(BITS)) i_tx (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .load  (evt.load),
        .shift (evt.shift),
        .din   (tx_data),
        .mosi  (mosi)
    );

    spi_eng_rx #(.W(BITS)) i_rx (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .sample (evt.sample),
        .miso   (miso),
        .dout   (rx_data)
    );

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } top_t;

    top_t top_d, top_q;

    always_comb begin
        top_d = top_q;
        if (xfer_en_n && done_i) top_d.cnt = '0;
        else if (evt.cnt_hit)    top_d.cnt = top_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) top_q <= '0;
        else     top_q <= top_d;
    end

    assign byte_count = top_q.cnt;
    assign tx_rd_n    = !evt.rd_hit;
    assign rx_wr_n    = !evt.wr_hit;
    assign sck        = run && (phase >= PH_HIGH);
    assign cs_n       = xfer_en_n;

    // R6: read strobe is a single-clock pulse
    p_rd_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        !tx_rd_n |=> tx_rd_n);

    // R7: write strobe is a single-clock pulse
    p_wr_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        !rx_wr_n |=> rx_wr_n);

    // R10 / R3: deselected link is quiet
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sck && !mosi && tx_rd_n && rx_wr_n));

    // R9: done with transfer off clears the counter
    p_cnt_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (xfer_en_n && done_i) |=> (byte_count == '0));

    // R9: the counter never moves while the transfer is off and done is low
    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (xfer_en_n && !done_i) |=> $stable(byte_count));
endmodule

// File: tb/test_spi_byte_engine.sv
`timescale 1ns/1ps
module test_spi_byte_engine;
    logic        clk = 1'b0;
    logic        rst;
    logic        xfer_en_n, send_en_n, recv_en_n, done_i;
    logic [7:0]  tx_data;
    logic        tx_rd_n;
    logic        miso;
    logic [7:0]  rx_data;
    logic        rx_wr_n, sck, mosi, cs_n;
    logic [15:0] byte_count;

    int checks = 0;
    int errors = 0;

    // {tx byte, miso byte}
    localparam logic [15:0] VEC [0:3] = '{16'hA53C, 16'hFF00, 16'h00FF, 16'h8196};

    always #2 clk = ~clk;

    spi_byte_engine i_spi_byte_engine (
        .clk        (clk),
        .rst        (rst),
        .xfer_en_n  (xfer_en_n),
        .send_en_n  (send_en_n),
        .recv_en_n  (recv_en_n),
        .done_i     (done_i),
        .tx_data    (tx_data),
        .tx_rd_n    (tx_rd_n),
        .miso       (miso),
        .rx_data    (rx_data),
        .rx_wr_n    (rx_wr_n),
        .sck        (sck),
        .mosi       (mosi),
        .cs_n       (cs_n),
        .byte_count (byte_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        rst = 1'b1; xfer_en_n = 1'b1; send_en_n = 1'b0; recv_en_n = 1'b0;
        done_i = 1'b0; tx_data = 8'h00; miso = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // Reset state, R3 and R10
        chk(cs_n == 1'b1, "R10 reset cs_n", cs_n, 1);
        chk(sck == 1'b0, "R3 reset sck", sck, 0);
        chk(mosi == 1'b0, "R3 reset mosi", mosi, 0);
        chk(tx_rd_n == 1'b1, "R6 reset tx_rd_n", tx_rd_n, 1);
        chk(rx_wr_n == 1'b1, "R7 reset rx_wr_n", rx_wr_n, 1);
        chk(byte_count == 16'd0, "R9 reset byte_count", byte_count, 0);

        // Streaming table: back-to-back bytes
        @(negedge clk);
        xfer_en_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] txb, mib;
            int sck_bad, mosi_bad, rd_bad, wr_bad;
            txb = VEC[k][15:8];
            mib = VEC[k][7:0];
            sck_bad = 0; mosi_bad = 0; rd_bad = 0; wr_bad = 0;
            for (int c = 0; c < 80; c++) begin
                if (c == 0) tx_data = txb;
                miso = mib[7 - c / 10];
                #1;
                if (sck !== ((c % 10) >= 5)) sck_bad++;
                if ((c % 10) == 5 && mosi !== txb[7 - c / 10]) mosi_bad++;
                if (tx_rd_n !== (c != 0)) rd_bad++;
                if (rx_wr_n !== (c != 76)) wr_bad++;
                if (c == 76) chk(rx_data == mib, "R5 rx byte", rx_data, mib);
                if (c == 78) chk(byte_count == 16'(k + 1), "R9 count", byte_count, k + 1);
                if (c == 40) chk(cs_n == 1'b0, "R10 cs_n active", cs_n, 0);
                @(negedge clk);
            end
            chk(sck_bad == 0, "R1 R8 sck waveform", sck_bad, 0);
            chk(mosi_bad == 0, "R4 mosi MSB first", mosi_bad, 0);
            chk(rd_bad == 0, "R6 read strobe phase", rd_bad, 0);
            chk(wr_bad == 0, "R2 R7 write strobe phase", wr_bad, 0);
        end

        // End of transfer without done: count holds, link idle
        xfer_en_n = 1'b1;
        @(negedge clk); @(negedge clk); #1;
        chk(byte_count == 16'd4, "R9 hold without done", byte_count, 4);
        chk(cs_n == 1'b1, "R10 cs_n idle", cs_n, 1);
        chk(sck == 1'b0 && mosi == 1'b0, "R3 idle sck mosi", {sck, mosi}, 0);

        // Done with transfer off clears the counter
        done_i = 1'b1;
        @(negedge clk); #1;
        chk(byte_count == 16'd0, "R9 clear on done", byte_count, 0);
        done_i = 1'b0;

        // Abort mid-byte, then restart at bit 0 phase 0
        @(negedge clk);
        xfer_en_n = 1'b0;
        repeat (23) @(negedge clk);
        xfer_en_n = 1'b1;
        @(negedge clk); #1;
        chk(sck == 1'b0 && cs_n == 1'b1, "R3 abort idle", {sck, cs_n}, 1);
        @(negedge clk);
        xfer_en_n = 1'b0;
        #1;
        chk(tx_rd_n == 1'b0, "R3 restart at phase 0", tx_rd_n, 0);
        @(negedge clk); #1;
        chk(tx_rd_n == 1'b1, "R6 single clock strobe", tx_rd_n, 1);
        xfer_en_n = 1'b1;
        repeat (2) @(negedge clk);

        // Send and receive disabled: no strobes, no load, count still moves
        send_en_n = 1'b1; recv_en_n = 1'b1; tx_data = 8'hFF; miso = 1'b1;
        begin
            int rd_lo, wr_lo, mosi_hi;
            rd_lo = 0; wr_lo = 0; mosi_hi = 0;
            xfer_en_n = 1'b0;
            for (int c = 0; c < 80; c++) begin
                #1;
                if (!tx_rd_n) rd_lo++;
                if (!rx_wr_n) wr_lo++;
                if (mosi) mosi_hi++;
                @(negedge clk);
            end
            chk(rd_lo == 0, "R6 read strobe gated", rd_lo, 0);
            chk(wr_lo == 0, "R7 write strobe gated", wr_lo, 0);
            chk(mosi_hi == 0, "R4 no load when send off", mosi_hi, 0);
            #1;
            chk(byte_count == 16'd1, "R9 count with strobes off", byte_count, 1);
        end
        xfer_en_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule